// File: doc/BRIEF.md
# Register Dependency Scoreboard

This block guards an in-order issue pipeline that interleaves several warps. Each warp shows the scoreboard one decoded candidate instruction, taken from the head of its instruction buffer. The candidate carries up to three source register IDs and one destination register ID, and each of these operands has its own valid bit. The scoreboard keeps one bit vector of pending writes for each warp. It compares every candidate against the bit vector of its own warp only. It drives a per-warp ready mask, and the issue scheduler selects only among warps whose bit in that mask is high. A hazarded warp is only masked; the rest of the pipe keeps running.

When the scheduler issues an instruction with a valid destination, the scoreboard sets that destination's pending bit on the same clock edge. When the execution side reports a writeback, the scoreboard clears the bit on that edge. The issue and writeback inputs are single-cycle event strobes, and the scoreboard accepts them in every cycle. It never pushes back on these strobes. The ready mask acts as the back-pressure on the candidate stream: a candidate whose ready bit is low stays in its buffer until a writeback clears the hazard.

Top module: `reg_scoreboard`

## Requirements
- R1: A candidate with any valid source slot whose register ID has its pending bit set in that warp drives its `ready_mask` bit low (read-after-write).
- R2: A candidate with a valid destination whose register ID has its pending bit set in that warp drives its `ready_mask` bit low (write-after-write).
- R3: `ready_mask[w]` is high exactly when `cand_valid[w]` is high and neither R1 nor R2 applies. It is combinational from the current pending state and the candidate inputs.
- R4: An `issue_valid` strobe with `issue_dst_valid` high sets the pending bit `issue_dst` of warp `issue_warp` on that clock edge. From the next cycle on, candidates see this bit.
- R5: A `wb_valid` strobe clears the pending bit `wb_reg` of warp `wb_warp` on that clock edge.
- R6: Issue and writeback events change only the pending bits of the warp they name. A hazard in one warp never lowers another warp's ready bit.
- R7: If an issue reservation and a writeback name the same warp and register in one cycle, the bit is set after the edge.
- R8: A source or destination slot whose valid bit is 0 never causes a hazard, whatever register ID it carries.
- R9: Reset (active-low `rst_n`) clears every pending bit of every warp.
- R10: An issue strobe with `issue_dst_valid` low reserves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | NUM_WARPS | Warp w has a candidate instruction |
| cand_src_valid | input | NUM_WARPS*3 | Source slot valid bits; the bit for warp w, slot k is at index w*3+k |
| cand_src | input | NUM_WARPS*3*RW | Source register IDs; the field for warp w, slot k starts at bit (w*3+k)*RW |
| cand_dst_valid | input | NUM_WARPS | Destination valid bit per warp |
| cand_dst | input | NUM_WARPS*RW | Destination register ID; the field for warp w starts at bit w*RW |
| ready_mask | output | NUM_WARPS | Candidate of warp w is free of hazards |
| issue_valid | input | 1 | Issue event strobe |
| issue_warp | input | WW | Warp that issued |
| issue_dst_valid | input | 1 | Issued instruction writes a register |
| issue_dst | input | RW | Register reserved by the issue |
| wb_valid | input | 1 | Writeback event strobe |
| wb_warp | input | WW | Warp being written back |
| wb_reg | input | RW | Register released by the writeback |

RW = clog2(NUM_REGS) and WW = clog2(NUM_WARPS).

## Verification
The bench places a hazard in the third source slot as well as in the first. A design that checked only some of the slots would let a dependent instruction issue early. It sets up an issue and a writeback on the same register in the same cycle. A design that let the release win would drop a live reservation and open a read-after-write window. It puts a pending register ID in an unused slot and in an issue with no destination. A design that ignored the valid bits would stall for no reason or leak reservations. It samples the ready mask both before and after the issue edge. It also places the same register ID in other warps, to catch a reservation that shows up a cycle late or a check that crosses warps.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Source operand slots per candidate instruction
  localparam int unsigned SRC_SLOTS = 3;
endpackage

// File: rtl/sb_resv_row.sv
// Pending-write bit vector for one warp.
module sb_resv_row #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned WARP_ID  = 0,
  parameter int unsigned WW       = 2,
  parameter int unsigned RW       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid,
  input  logic [WW-1:0]       issue_warp,
  input  logic                issue_dst_valid,
  input  logic [RW-1:0]       issue_dst,
  input  logic                wb_valid,
  input  logic [WW-1:0]       wb_warp,
  input  logic [RW-1:0]       wb_reg,
  output logic [NUM_REGS-1:0] resv
);
  localparam logic [WW-1:0] MY_WARP = WW'(WARP_ID);

  logic                set_hit, clr_hit;
  logic [NUM_REGS-1:0] set_vec, clr_vec;

  assign set_hit = issue_valid && issue_dst_valid && (issue_warp == MY_WARP);
  assign clr_hit = wb_valid && (wb_warp == MY_WARP);

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (set_hit && (issue_dst == RW'(r))) set_vec[r] = 1'b1;
      if (clr_hit && (wb_reg == RW'(r)))    clr_vec[r] = 1'b1;
    end
  end

  // Clear first, then set: a same-cycle reservation survives its release
  always_ff @(posedge clk) begin
    if (!rst_n) resv <= '0;
    else        resv <= (resv & ~clr_vec) | set_vec;
  end

  a_r4_issue_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> resv[$past(issue_dst)]);

  a_r5_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !(set_hit && issue_dst == wb_reg)) |=> !resv[$past(wb_reg)]);

  a_r7_reserve_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && set_hit && issue_dst == wb_reg) |=> resv[$past(issue_dst)]);

  a_r6_no_foreign_set: assert property (@(posedge clk) disable iff (!rst_n)
    !set_hit |=> (resv & ~$past(resv)) == '0);

  a_r6_no_foreign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> ($past(resv) & ~resv) == '0);
endmodule

// File: rtl/sb_hazard_chk.sv
// Compares one warp's candidate against that warp's pending bits.
module sb_hazard_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned RW       = 5,
  parameter int unsigned NSRC     = 3
) (
  input  logic [NUM_REGS-1:0] resv,
  input  logic                cand_valid,
  input  logic [NSRC-1:0]     src_valid,
  input  logic [NSRC*RW-1:0]  src,
  input  logic                dst_valid,
  input  logic [RW-1:0]       dst,
  output logic                ready
);
  logic [NSRC-1:0] raw_hit;
  logic            waw_hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign raw_hit[k] = src_valid[k] && resv[src[k*RW +: RW]];
  end

  assign waw_hit = dst_valid && resv[dst];
  assign ready   = cand_valid && !(|raw_hit) && !waw_hit;

  always_comb begin
    if (ready) a_r1_raw_blocks: assert (raw_hit == '0);
  end
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 4,
  parameter int unsigned NUM_REGS  = 32,
  localparam int unsigned RW = $clog2(NUM_REGS),
  localparam int unsigned WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int unsigned NS = SRC_SLOTS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_WARPS-1:0]    cand_valid,
  input  logic [NUM_WARPS*NS-1:0] cand_src_valid,
  input  logic [NUM_WARPS*NS*RW-1:0] cand_src,
  input  logic [NUM_WARPS-1:0]    cand_dst_valid,
  input  logic [NUM_WARPS*RW-1:0] cand_dst,
  output logic [NUM_WARPS-1:0]    ready_mask,
  input  logic                    issue_valid,
  input  logic [WW-1:0]           issue_warp,
  input  logic                    issue_dst_valid,
  input  logic [RW-1:0]           issue_dst,
  input  logic                    wb_valid,
  input  logic [WW-1:0]           wb_warp,
  input  logic [RW-1:0]           wb_reg
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [NUM_REGS-1:0] resv;

    sb_resv_row #(.NUM_REGS(NUM_REGS), .WARP_ID(w), .WW(WW), .RW(RW)) u_row (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_warp(issue_warp),
      .issue_dst_valid(issue_dst_valid), .issue_dst(issue_dst),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
      .resv(resv)
    );

    sb_hazard_chk #(.NUM_REGS(NUM_REGS), .RW(RW), .NSRC(NS)) u_chk (
      .resv(resv),
      .cand_valid(cand_valid[w]),
      .src_valid(cand_src_valid[w*NS +: NS]),
      .src(cand_src[w*NS*RW +: NS*RW]),
      .dst_valid(cand_dst_valid[w]),
      .dst(cand_dst[w*RW +: RW]),
      .ready(ready_mask[w])
    );
  end

  a_r3_ready_needs_cand: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_mask & ~cand_valid) == '0);
endmodule

// File: tb/sim_reg_scoreboard.sv
`timescale 1ns/1ps
module sim_reg_scoreboard;
  localparam int NW = 4, NR = 32, RW = 5, WW = 2, NS = 3;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          cv [NW];
  logic          sv [NW][NS];
  logic [RW-1:0] s  [NW][NS];
  logic          dv [NW];
  logic [RW-1:0] d  [NW];

  logic [NW-1:0]       cand_valid, cand_dst_valid, ready_mask;
  logic [NW*NS-1:0]    cand_src_valid;
  logic [NW*NS*RW-1:0] cand_src;
  logic [NW*RW-1:0]    cand_dst;
  logic issue_valid = 0, issue_dst_valid = 0, wb_valid = 0;
  logic [WW-1:0] issue_warp = 0, wb_warp = 0;
  logic [RW-1:0] issue_dst = 0, wb_reg = 0;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      cand_valid[w]        = cv[w];
      cand_dst_valid[w]    = dv[w];
      cand_dst[w*RW +: RW] = d[w];
      for (int k = 0; k < NS; k++) begin
        cand_src_valid[w*NS+k]        = sv[w][k];
        cand_src[(w*NS+k)*RW +: RW]   = s[w][k];
      end
    end
  end

  reg_scoreboard #(.NUM_WARPS(NW), .NUM_REGS(NR)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cand_valid(cand_valid), .cand_src_valid(cand_src_valid), .cand_src(cand_src),
    .cand_dst_valid(cand_dst_valid), .cand_dst(cand_dst), .ready_mask(ready_mask),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_dst_valid(issue_dst_valid), .issue_dst(issue_dst),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg)
  );

  int checks = 0, fails = 0;

  task automatic chk(input logic [NW-1:0] act, input logic [NW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s ready_mask actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Every warp: valid candidate, all slots unused
  task automatic clear_cands();
    for (int w = 0; w < NW; w++) begin
      cv[w] = 1; dv[w] = 0; d[w] = 0;
      for (int k = 0; k < NS; k++) begin sv[w][k] = 0; s[w][k] = 0; end
    end
  endtask

  // Events are driven after a falling edge and held across one rising edge
  task automatic do_issue(input int w, input logic dvld, input int r);
    issue_valid = 1; issue_warp = WW'(w); issue_dst_valid = dvld; issue_dst = RW'(r);
    @(negedge clk);
    issue_valid = 0; issue_dst_valid = 0;
  endtask

  task automatic do_wb(input int w, input int r);
    wb_valid = 1; wb_warp = WW'(w); wb_reg = RW'(r);
    @(negedge clk);
    wb_valid = 0;
  endtask

  task automatic t_reset();
    clear_cands();
    for (int w = 0; w < NW; w++) begin
      sv[w][0] = 1; s[w][0] = RW'(w * 7); dv[w] = 1; d[w] = RW'(w + 1);
    end
    #1 chk(ready_mask, 4'b1111, "R9 reset leaves nothing pending");
  endtask

  task automatic t_raw();
    clear_cands();
    sv[1][0] = 1; s[1][0] = 5;
    sv[0][0] = 1; s[0][0] = 5;
    sv[2][2] = 1; s[2][2] = 5;
    issue_valid = 1; issue_warp = 1; issue_dst_valid = 1; issue_dst = 5;
    #1 chk(ready_mask, 4'b1111, "R4 no reservation before edge");
    @(negedge clk);
    issue_valid = 0; issue_dst_valid = 0;
    #1 chk(ready_mask, 4'b1101, "R1 slot0 RAW in warp1, R6 others free");
    sv[1][0] = 0; sv[1][2] = 1; s[1][2] = 5;
    #1 chk(ready_mask, 4'b1101, "R1 slot2 RAW");
  endtask

  task automatic t_waw();
    clear_cands();
    dv[1] = 1; d[1] = 5;
    #1 chk(ready_mask, 4'b1101, "R2 WAW blocks warp1");
    cv[3] = 0;
    #1 chk(ready_mask, 4'b0101, "R3 no candidate no ready");
  endtask

  task automatic t_unused();
    clear_cands();
    for (int k = 0; k < NS; k++) s[1][k] = 5;
    d[1] = 5;
    #1 chk(ready_mask, 4'b1111, "R8 unused slots with pending id");
  endtask

  task automatic t_wb();
    clear_cands();
    sv[1][1] = 1; s[1][1] = 5;
    do_wb(1, 5);
    #1 chk(ready_mask, 4'b1111, "R5 writeback releases reg");
  endtask

  task automatic t_collision();
    clear_cands();
    sv[2][0] = 1; s[2][0] = 7;
    do_issue(2, 1, 7);
    #1 chk(ready_mask, 4'b1011, "R4 warp2 r7 reserved");
    issue_valid = 1; issue_warp = 2; issue_dst_valid = 1; issue_dst = 7;
    wb_valid = 1; wb_warp = 2; wb_reg = 7;
    @(negedge clk);
    issue_valid = 0; issue_dst_valid = 0; wb_valid = 0;
    #1 chk(ready_mask, 4'b1011, "R7 reservation wins collision");
    do_wb(3, 7);
    #1 chk(ready_mask, 4'b1011, "R6 other-warp writeback ignored");
    do_wb(2, 7);
    #1 chk(ready_mask, 4'b1111, "R5 final release");
  endtask

  task automatic t_nodst();
    clear_cands();
    sv[3][0] = 1; s[3][0] = 9; dv[3] = 1; d[3] = 9;
    do_issue(3, 0, 9);
    #1 chk(ready_mask, 4'b1111, "R10 issue without dst reserves nothing");
  endtask

  task automatic t_rereset();
    clear_cands();
    do_issue(0, 1, 31);
    sv[0][0] = 1; s[0][0] = 31;
    #1 chk(ready_mask, 4'b1110, "R4 top register reserved");
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1 chk(ready_mask, 4'b1111, "R9 reset clears pending bits");
  endtask

  initial begin
    fork
      begin
        clear_cands();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        @(negedge clk); t_raw();
        @(negedge clk); t_waw();
        @(negedge clk); t_unused();
        @(negedge clk); t_wb();
        @(negedge clk); t_collision();
        @(negedge clk); t_nodst();
        @(negedge clk); t_rereset();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule